// File: doc/BRIEF.md
# Multi-Resource Threadblock Dispatcher

This block places queued thread groups (CTAs) onto a set of compute cores. Each request carries a CTA identifier and three demands: warp slots, registers and shared-memory units. Requests wait in a small FIFO outside the cores. Each cycle the head entry is offered to the cores in round-robin order, starting at the core after the one that received the previous CTA. The first core that is enabled and has enough of all three resources free takes the CTA. All three amounts are deducted in the same cycle.

A placed CTA holds its resources until its core reports a completion pulse with the amounts to give back. The dispatcher never preempts a CTA and never takes resources back on its own. A per-core enable lets an external throttle keep a core from receiving new work while its resident CTAs finish. When the head CTA fits nowhere, the FIFO stalls in order and later entries are not reordered around it. A release that would push a pool above its capacity saturates the pool and sets a sticky error flag for that core.

Top module: `cta_dispatcher`

## Requirements
- R1: After reset, `disp_valid` is 0, `req_ready` is 1, every `rel_err` bit is 0, and every core has its full warp, register and shared-memory capacity free.
- R2: A CTA is granted to a core only if its warp, register and shared-memory demands are each no larger than that core's free amount. At most one CTA is granted per cycle. The grant appears on `disp_valid`/`disp_core`/`disp_id` in the cycle after the head entry is examined.
- R3: A grant deducts all three demands from the chosen core at once. The fit test in later cycles sees all three deductions together.
- R4: The search for a core starts at core 0 after reset. After each grant it starts at the core that follows the one just granted, wrapping from the last core to core 0.
- R5: A core whose `core_en` bit is 0 receives no CTA, even when its resources are free.
- R6: Requests are dispatched in arrival order. If the head fits on no enabled core, nothing is dispatched, and entries behind it wait even if they would fit.
- R7: Free resources on a core grow only on a `done_pulse` for that core, by the amounts given on `done_warps`/`done_regs`/`done_smem` for that core. Until then a placed CTA keeps its resources.
- R8: A request is accepted on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 exactly while the FIFO holds QDEPTH entries (default 4). Requests offered while it is 0 are dropped.
- R9: If a release exceeds the amount in use for any of the three pools, that pool saturates at its capacity. The core's `rel_err` bit becomes 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A new CTA request is offered |
| req_ready | output | 1 | The queue can accept a request |
| req_id | input | ID_W | Identifier of the offered CTA |
| req_warps | input | WW | Warp slots demanded |
| req_regs | input | RW | Registers demanded |
| req_smem | input | SW | Shared-memory units demanded |
| core_en | input | NUM_CORES | Per-core permission to receive new CTAs |
| done_pulse | input | NUM_CORES | Per-core completion pulse |
| done_warps | input | NUM_CORES*WW | Per-core warp slots released, core c at bits c*WW upward |
| done_regs | input | NUM_CORES*RW | Per-core registers released, same packing |
| done_smem | input | NUM_CORES*SW | Per-core shared memory released, same packing |
| disp_valid | output | 1 | A CTA was placed in the previous cycle |
| disp_core | output | CW | Core that received the CTA |
| disp_id | output | ID_W | Identifier of the placed CTA |
| rel_err | output | NUM_CORES | Sticky per-core over-release flag |

## Verification
A free counter that is wrong in the block first shows at the ports as a grant that should not happen, or as a stall where a grant was due. This appears on `disp_valid` and `disp_core` one cycle after the head entry meets the affected core. A counter that gains resources without a release, or that misses a deduction, may show up only several CTAs later, when that core fills up. A round-robin pointer that advances wrongly shows on the very next dispatch as the wrong `disp_core`. A queue pointer error shows as a wrong `disp_id` or as a `req_ready` change that comes one entry too early or too late.

// File: rtl/cta_disp_pkg.sv
package cta_disp_pkg;
  parameter int DEF_CORES   = 4;
  parameter int DEF_WARPS   = 32;
  parameter int DEF_REGS    = 512;
  parameter int DEF_SMEM    = 128;
  parameter int DEF_QDEPTH  = 4;
  parameter int DEF_ID_W    = 6;

  function automatic int cnt_w(input int cap);
    return $clog2(cap + 1);
  endfunction

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cta_disp_fifo.sv
module cta_disp_fifo
  import cta_disp_pkg::*;
#(
  parameter int EW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] din,
  input  logic          pop,
  output logic [EW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int AW = idx_w(DEPTH);
  localparam int CNW = cnt_w(DEPTH);

  logic [EW-1:0]  mem_q [DEPTH];
  logic [AW-1:0]  wr_q, wr_d, rd_q, rd_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           do_push, do_pop;

  assign full    = (cnt_q == CNW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din;
  end
endmodule

// File: rtl/cta_res_ctr.sv
module cta_res_ctr #(
  parameter int CAP = 32,
  localparam int W = $clog2(CAP + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alloc_en,
  input  logic [W-1:0] alloc_amt,
  input  logic         rel_en,
  input  logic [W-1:0] rel_amt,
  output logic [W-1:0] free_cnt,
  output logic         over
);
  logic [W-1:0] free_q, free_d, used, sat;
  logic [W:0]   sum;
  logic         upd;

  always_comb begin
    used  = W'(CAP) - free_q;
    over  = rel_en && (rel_amt > used);
    sum   = {1'b0, free_q} + {1'b0, (rel_en ? rel_amt : '0)};
    sat   = over ? W'(CAP) : sum[W-1:0];
    free_d = sat - (alloc_en ? alloc_amt : '0);
    upd   = alloc_en || rel_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   free_q <= W'(CAP);
    else if (upd) free_q <= free_d;
  end

  assign free_cnt = free_q;
endmodule

// File: rtl/cta_core_pool.sv
module cta_core_pool
  import cta_disp_pkg::*;
#(
  parameter int WARP_CAP = 32,
  parameter int REG_CAP  = 512,
  parameter int SMEM_CAP = 128,
  localparam int WW = cnt_w(WARP_CAP),
  localparam int RW = cnt_w(REG_CAP),
  localparam int SW = cnt_w(SMEM_CAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic [WW-1:0] alloc_w,
  input  logic [RW-1:0] alloc_r,
  input  logic [SW-1:0] alloc_s,
  input  logic          rel_en,
  input  logic [WW-1:0] rel_w,
  input  logic [RW-1:0] rel_r,
  input  logic [SW-1:0] rel_s,
  output logic [WW-1:0] free_w,
  output logic [RW-1:0] free_r,
  output logic [SW-1:0] free_s,
  output logic          err
);
  logic ov_w, ov_r, ov_s, err_q, err_d;

  cta_res_ctr #(.CAP(WARP_CAP)) warp_ctr_i (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_amt(alloc_w),
    .rel_en(rel_en), .rel_amt(rel_w), .free_cnt(free_w), .over(ov_w));

  cta_res_ctr #(.CAP(REG_CAP)) reg_ctr_i (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_amt(alloc_r),
    .rel_en(rel_en), .rel_amt(rel_r), .free_cnt(free_r), .over(ov_r));

  cta_res_ctr #(.CAP(SMEM_CAP)) smem_ctr_i (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_amt(alloc_s),
    .rel_en(rel_en), .rel_amt(rel_s), .free_cnt(free_s), .over(ov_s));

  always_comb err_d = err_q || ov_w || ov_r || ov_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;
endmodule

// File: rtl/cta_rr_pick.sv
module cta_rr_pick
  import cta_disp_pkg::*;
#(
  parameter int N = 4,
  localparam int CW = idx_w(N)
) (
  input  logic [N-1:0]  cand,
  input  logic [CW-1:0] start,
  output logic          found,
  output logic [CW-1:0] idx,
  output logic [CW-1:0] nxt
);
  localparam int XW = CW + 1;

  always_comb begin
    logic [XW-1:0] pos;
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      pos = {1'b0, start} + XW'(k);
      if (pos >= XW'(N)) pos = pos - XW'(N);
      if (!found && cand[pos[CW-1:0]]) begin
        found = 1'b1;
        idx   = pos[CW-1:0];
      end
    end
    nxt = (idx == CW'(N - 1)) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/cta_dispatcher.sv
module cta_dispatcher
  import cta_disp_pkg::*;
#(
  parameter int NUM_CORES = DEF_CORES,
  parameter int WARP_CAP  = DEF_WARPS,
  parameter int REG_CAP   = DEF_REGS,
  parameter int SMEM_CAP  = DEF_SMEM,
  parameter int QDEPTH    = DEF_QDEPTH,
  parameter int ID_W      = DEF_ID_W,
  localparam int WW = cnt_w(WARP_CAP),
  localparam int RW = cnt_w(REG_CAP),
  localparam int SW = cnt_w(SMEM_CAP),
  localparam int CW = idx_w(NUM_CORES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ID_W-1:0]         req_id,
  input  logic [WW-1:0]           req_warps,
  input  logic [RW-1:0]           req_regs,
  input  logic [SW-1:0]           req_smem,
  input  logic [NUM_CORES-1:0]    core_en,
  input  logic [NUM_CORES-1:0]    done_pulse,
  input  logic [NUM_CORES*WW-1:0] done_warps,
  input  logic [NUM_CORES*RW-1:0] done_regs,
  input  logic [NUM_CORES*SW-1:0] done_smem,
  output logic                    disp_valid,
  output logic [CW-1:0]           disp_core,
  output logic [ID_W-1:0]         disp_id,
  output logic [NUM_CORES-1:0]    rel_err
);
  localparam int EW = ID_W + WW + RW + SW;

  // reset: asserted at once, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // pending queue
  logic [EW-1:0]   head;
  logic            q_full, q_empty, grant_vld;
  logic [ID_W-1:0] head_id;
  logic [WW-1:0]   head_w;
  logic [RW-1:0]   head_r;
  logic [SW-1:0]   head_s;

  cta_disp_fifo #(.EW(EW), .DEPTH(QDEPTH)) queue_i (
    .clk(clk), .rst_n(rst_sn),
    .push(req_valid), .din({req_id, req_warps, req_regs, req_smem}),
    .pop(grant_vld), .dout(head), .full(q_full), .empty(q_empty));

  assign req_ready = !q_full;
  assign {head_id, head_w, head_r, head_s} = head;

  // per-core pools
  logic [NUM_CORES-1:0][WW-1:0] free_w;
  logic [NUM_CORES-1:0][RW-1:0] free_r;
  logic [NUM_CORES-1:0][SW-1:0] free_s;
  logic [NUM_CORES-1:0]         fit, alloc_vec;
  logic [CW-1:0]                grant_idx, ptr_q, ptr_nxt;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign fit[c] = core_en[c] && !q_empty &&
                    (head_w <= free_w[c]) &&
                    (head_r <= free_r[c]) &&
                    (head_s <= free_s[c]);
    assign alloc_vec[c] = grant_vld && (grant_idx == CW'(c));

    cta_core_pool #(.WARP_CAP(WARP_CAP), .REG_CAP(REG_CAP), .SMEM_CAP(SMEM_CAP)) pool_i (
      .clk(clk), .rst_n(rst_sn),
      .alloc_en(alloc_vec[c]), .alloc_w(head_w), .alloc_r(head_r), .alloc_s(head_s),
      .rel_en(done_pulse[c]),
      .rel_w(done_warps[c*WW +: WW]), .rel_r(done_regs[c*RW +: RW]),
      .rel_s(done_smem[c*SW +: SW]),
      .free_w(free_w[c]), .free_r(free_r[c]), .free_s(free_s[c]),
      .err(rel_err[c]));
  end

  // round-robin placement
  cta_rr_pick #(.N(NUM_CORES)) pick_i (
    .cand(fit), .start(ptr_q), .found(grant_vld), .idx(grant_idx), .nxt(ptr_nxt));

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)        ptr_q <= '0;
    else if (grant_vld) ptr_q <= ptr_nxt;
  end

  // dispatch report
  logic            dv_q;
  logic [CW-1:0]   dc_q;
  logic [ID_W-1:0] di_q;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      dv_q <= 1'b0;
      dc_q <= '0;
      di_q <= '0;
    end else begin
      dv_q <= grant_vld;
      if (grant_vld) begin
        dc_q <= grant_idx;
        di_q <= head_id;
      end
    end
  end

  assign disp_valid = dv_q;
  assign disp_core  = dc_q;
  assign disp_id    = di_q;
endmodule

// File: rtl/cta_dispatcher_chk.sv
module cta_dispatcher_chk
  import cta_disp_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int WARP_CAP  = 32,
  parameter int REG_CAP   = 512,
  parameter int SMEM_CAP  = 128,
  localparam int WW = cnt_w(WARP_CAP),
  localparam int RW = cnt_w(REG_CAP),
  localparam int SW = cnt_w(SMEM_CAP),
  localparam int CW = idx_w(NUM_CORES)
) (
  input logic                         clk,
  input logic                         rst_sn,
  input logic [NUM_CORES-1:0]         core_en,
  input logic [NUM_CORES-1:0]         done_pulse,
  input logic [NUM_CORES-1:0]         alloc_vec,
  input logic                         grant_vld,
  input logic [CW-1:0]                grant_idx,
  input logic [WW-1:0]                head_w,
  input logic [RW-1:0]                head_r,
  input logic [SW-1:0]                head_s,
  input logic [NUM_CORES-1:0][WW-1:0] free_w,
  input logic [NUM_CORES-1:0][RW-1:0] free_r,
  input logic [NUM_CORES-1:0][SW-1:0] free_s,
  input logic [NUM_CORES-1:0]         rel_err,
  input logic                         disp_valid
);
  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(alloc_vec));

  p_fit_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    grant_vld |-> (head_w <= free_w[grant_idx] && head_r <= free_r[grant_idx] &&
                   head_s <= free_s[grant_idx]));

  p_report_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    grant_vld |=> disp_valid);

  p_enable_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    grant_vld |-> core_en[grant_idx]);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    p_take_all_r3: assert property (@(posedge clk) disable iff (!rst_sn)
      (alloc_vec[c] && !done_pulse[c]) |=>
        (free_w[c] == $past(free_w[c]) - $past(head_w) &&
         free_r[c] == $past(free_r[c]) - $past(head_r) &&
         free_s[c] == $past(free_s[c]) - $past(head_s)));

    p_no_gain_r7: assert property (@(posedge clk) disable iff (!rst_sn)
      !done_pulse[c] |=> (free_w[c] <= $past(free_w[c]) &&
                          free_r[c] <= $past(free_r[c]) &&
                          free_s[c] <= $past(free_s[c])));

    p_cap_r9: assert property (@(posedge clk) disable iff (!rst_sn)
      free_w[c] <= WW'(WARP_CAP) && free_r[c] <= RW'(REG_CAP) &&
      free_s[c] <= SW'(SMEM_CAP));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_sn)
      rel_err[c] |=> rel_err[c]);
  end
endmodule

bind cta_dispatcher cta_dispatcher_chk #(
  .NUM_CORES(NUM_CORES), .WARP_CAP(WARP_CAP), .REG_CAP(REG_CAP), .SMEM_CAP(SMEM_CAP)
) chk_i (
  .clk(clk), .rst_sn(rst_sn), .core_en(core_en), .done_pulse(done_pulse),
  .alloc_vec(alloc_vec), .grant_vld(grant_vld), .grant_idx(grant_idx),
  .head_w(head_w), .head_r(head_r), .head_s(head_s),
  .free_w(free_w), .free_r(free_r), .free_s(free_s),
  .rel_err(rel_err), .disp_valid(disp_valid)
);

// File: tb/cta_dispatcher_tb_top.sv
module cta_dispatcher_tb_top;
  localparam int NC = 4;
  localparam int WCAP = 32;
  localparam int RCAP = 512;
  localparam int SCAP = 128;
  localparam int QD = 4;
  localparam int IDW = 6;
  localparam int WW = 6;
  localparam int RW = 10;
  localparam int SW = 8;
  localparam int CW = 2;
  localparam int RMAX = 40;

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [IDW-1:0] req_id;
  logic [WW-1:0] req_warps;
  logic [RW-1:0] req_regs;
  logic [SW-1:0] req_smem;
  logic [NC-1:0] core_en, done_pulse, rel_err;
  logic [NC*WW-1:0] done_warps;
  logic [NC*RW-1:0] done_regs;
  logic [NC*SW-1:0] done_smem;
  logic disp_valid;
  logic [CW-1:0] disp_core;
  logic [IDW-1:0] disp_id;

  cta_dispatcher dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_warps(req_warps), .req_regs(req_regs), .req_smem(req_smem),
    .core_en(core_en), .done_pulse(done_pulse), .done_warps(done_warps),
    .done_regs(done_regs), .done_smem(done_smem), .disp_valid(disp_valid),
    .disp_core(disp_core), .disp_id(disp_id), .rel_err(rel_err));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int nchk, nerr;
  bit finished;

  // reference model state
  int mfw[NC], mfr[NC], mfs[NC];
  bit merr[NC];
  int mptr, qhead, qcnt;
  int qid[QD], qw[QD], qr[QD], qs[QD];
  int rcnt[NC];
  int resw[NC][RMAX], resr[NC][RMAX], ress[NC][RMAX];
  bit exp_valid;
  int exp_core, exp_id;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        mfw[c] = WCAP; mfr[c] = RCAP; mfs[c] = SCAP; merr[c] = 0; rcnt[c] = 0;
      end
      mptr = 0; qhead = 0; qcnt = 0; exp_valid = 0; exp_core = 0; exp_id = 0;
    end else begin : model_step
      bit g;
      int gi, cnt0, hid, hw, hr, hs, dw, dr, ds, tl;
      g = 0; gi = 0; cnt0 = qcnt;
      hid = qid[qhead]; hw = qw[qhead]; hr = qr[qhead]; hs = qs[qhead];
      if (cnt0 > 0)
        for (int k = 0; k < NC; k++) begin
          int c;
          c = (mptr + k) % NC;
          if (!g && core_en[c] && hw <= mfw[c] && hr <= mfr[c] && hs <= mfs[c]) begin
            g = 1; gi = c;
          end
        end
      for (int c = 0; c < NC; c++)
        if (done_pulse[c]) begin
          dw = int'(done_warps[c*WW +: WW]);
          dr = int'(done_regs[c*RW +: RW]);
          ds = int'(done_smem[c*SW +: SW]);
          if (dw > WCAP - mfw[c] || dr > RCAP - mfr[c] || ds > SCAP - mfs[c]) merr[c] = 1;
          mfw[c] = (mfw[c] + dw > WCAP) ? WCAP : mfw[c] + dw;
          mfr[c] = (mfr[c] + dr > RCAP) ? RCAP : mfr[c] + dr;
          mfs[c] = (mfs[c] + ds > SCAP) ? SCAP : mfs[c] + ds;
        end
      if (g) begin
        mfw[gi] -= hw; mfr[gi] -= hr; mfs[gi] -= hs;
        resw[gi][rcnt[gi]] = hw; resr[gi][rcnt[gi]] = hr; ress[gi][rcnt[gi]] = hs;
        rcnt[gi]++;
        mptr = (gi + 1) % NC;
        qhead = (qhead + 1) % QD; qcnt--;
        exp_core = gi; exp_id = hid;
      end
      exp_valid = g;
      if (req_valid && cnt0 < QD) begin
        tl = (qhead + qcnt) % QD;
        qid[tl] = int'(req_id); qw[tl] = int'(req_warps);
        qr[tl] = int'(req_regs); qs[tl] = int'(req_smem);
        qcnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic compare(input string tag);
    chk(disp_valid == exp_valid, tag, "disp_valid", disp_valid, exp_valid);
    if (exp_valid && disp_valid) begin
      chk(int'(disp_core) == exp_core, tag, "disp_core", disp_core, exp_core);
      chk(int'(disp_id) == exp_id, tag, "disp_id", disp_id, exp_id);
    end
    chk(req_ready == (qcnt < QD), tag, "req_ready", req_ready, qcnt < QD);
    for (int c = 0; c < NC; c++)
      chk(rel_err[c] == merr[c], tag, "rel_err", rel_err[c], merr[c]);
  endtask

  task automatic step(input string tag);
    @(negedge clk);
    compare(tag);
    req_valid = 1'b0;
    done_pulse = '0;
  endtask

  task automatic offer(input int id, input int w, input int r, input int s);
    req_valid = 1'b1;
    req_id = IDW'(id); req_warps = WW'(w); req_regs = RW'(r); req_smem = SW'(s);
  endtask

  task automatic release_oldest(input int c);
    done_pulse[c] = 1'b1;
    done_warps[c*WW +: WW] = WW'(resw[c][0]);
    done_regs[c*RW +: RW] = RW'(resr[c][0]);
    done_smem[c*SW +: SW] = SW'(ress[c][0]);
    for (int i = 0; i < RMAX - 1; i++) begin
      resw[c][i] = resw[c][i+1]; resr[c][i] = resr[c][i+1]; ress[c][i] = ress[c][i+1];
    end
    rcnt[c]--;
  endtask

  task automatic drain(input string tag);
    for (int it = 0; it < 400; it++) begin
      bit idle;
      step(tag);
      core_en = '1;
      idle = (qcnt == 0);
      for (int c = 0; c < NC; c++) begin
        if (rcnt[c] > 0) begin
          idle = 0;
          release_oldest(c);
        end
      end
      if (idle) break;
    end
    step(tag);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int id;
    nchk = 0; nerr = 0; finished = 0; id = 1;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_warps = '0; req_regs = '0;
    req_smem = '0; core_en = '1; done_pulse = '0; done_warps = '0; done_regs = '0;
    done_smem = '0;
    repeat (3) step("R1");
    rst_n = 1'b1;
    repeat (4) step("R1");

    // R4: four small CTAs land on cores 0,1,2,3 in turn
    for (int i = 0; i < 4; i++) begin offer(id, 2, 8, 4); id++; step("R4"); end
    repeat (3) step("R4");
    drain("R4");

    // R5: cores 1 and 3 disabled
    core_en = 4'b0101;
    for (int i = 0; i < 4; i++) begin offer(id, 3, 16, 2); id++; step("R5"); end
    repeat (4) step("R5");
    drain("R5");

    // R6: fill every core, then a large head blocks a small follower
    for (int i = 0; i < 4; i++) begin offer(id, WCAP, 10, 1); id++; step("R6"); end
    repeat (4) step("R6");
    offer(id, 20, 10, 1); id++; step("R6");
    offer(id, 2, 10, 1); id++; step("R6");
    repeat (4) step("R6");
    chk(qcnt == 2 && !disp_valid, "R6", "stalled queue", disp_valid, 0);
    release_oldest(1);
    repeat (5) step("R6");
    drain("R6");

    // R8: no core enabled, queue fills to QD and drops the rest
    core_en = '0;
    for (int i = 0; i < QD + 2; i++) begin offer(id, 1, 1, 1); id++; step("R8"); end
    chk(!req_ready, "R8", "ready while full", req_ready, 0);
    drain("R8");

    // R9: release with nothing resident on core 2
    done_pulse[2] = 1'b1;
    done_warps[2*WW +: WW] = WW'(3);
    done_regs[2*RW +: RW] = RW'(0);
    done_smem[2*SW +: SW] = SW'(0);
    step("R9");
    chk(rel_err == 4'b0100, "R9", "rel_err", rel_err, 4'b0100);
    for (int i = 0; i < 4; i++) begin offer(id, WCAP, RCAP, SCAP); id++; step("R9"); end
    repeat (3) step("R9");
    chk(rel_err == 4'b0100, "R9", "sticky rel_err", rel_err, 4'b0100);
    drain("R9");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      string tag;
      tag = (n < 1500) ? "R2" : "R3";
      step(tag);
      if ($urandom % 16 == 0) core_en[$urandom % NC] = ~core_en[$urandom % NC];
      if ($urandom % 2 == 0) begin
        if ($urandom % 8 == 0)
          offer(id, 16 + $urandom % 17, $urandom % RCAP, $urandom % (SCAP + 1));
        else
          offer(id, 1 + $urandom % 8, $urandom % 128, $urandom % 32);
        id = (id + 1) % 64;
      end
      for (int c = 0; c < NC; c++)
        if (rcnt[c] > 0 && $urandom % 3 == 0) release_oldest(c);
    end
    drain("R7");
    for (int c = 0; c < NC; c++)
      chk(mfw[c] == WCAP && rcnt[c] == 0, "R7", "core idle after drain", rcnt[c], 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule